// File: doc/BRIEF.md
# DMA Interrupt Coalescer

This block sits beside one channel of a descriptor-driven DMA engine and decides when that channel should interrupt the host. It does not interrupt on every finished frame. Instead it counts completions down from a programmable threshold and raises a completion event when the count runs out. A one-shot inactivity timer restarts on each completion and raises a delay event if no further completion arrives before it expires. When the timer expires, the completion counter also starts over from the threshold. Any frames counted so far are then reported through the delay event, and the next batch begins from a full count.

The surrounding register file holds the control and status words. It feeds the control word and the stored pending flags into this block. It latches the two one-cycle set pulses that the block produces into its status bits, and it reads back the live counter and timer values for status reads. The interrupt line is the pending flags ANDed with the enable bits that occupy the same positions in the control word, then ORed together. The timer ticks at a rate derived from a reference clock frequency and a requested timer frequency.

Top module: `irq_coalescer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `live_cnt` is 1, `live_tmr` is 0, and neither set pulse is asserted.
- R2: Each `frame_done` pulse lowers `live_cnt` by one. A `frame_done` that arrives while `live_cnt` is 1 asserts `cmpl_set` in the same cycle and reloads `live_cnt` from the threshold field `ctrl_reg[23:16]`.
- R3: A threshold of 0 makes the counter wrap through 255, so `cmpl_set` fires on the 256th frame after a reload.
- R4: A `frame_done` with a nonzero delay field `ctrl_reg[31:24]` loads `live_tmr` with that value, even while the timer is running. A `frame_done` with a delay of 0 leaves the timer running untouched.
- R5: A running timer (`live_tmr` nonzero) decrements once per tick. The tick on which it steps from 1 to 0 asserts `dly_set` in that cycle and reloads `live_cnt` from the threshold.
- R6: A `ctrl_wr` pulse reloads `live_cnt` from the threshold field on the next edge, and this takes priority over a decrement.
- R7: When a final completion and a timer expiry fall in the same cycle, both `cmpl_set` and `dly_set` are asserted and `live_cnt` takes the threshold value once.
- R8: `irq` equals the OR over three bits of `pend_flags[k] & ctrl_reg[12+k]`, where `pend_flags[0]` is the completion flag, `pend_flags[1]` is the delay flag and `pend_flags[2]` is reserved.
- R9: The timer ticks once every REF_HZ/TIMER_HZ clock cycles, so a delay of D expires between (D-1)·DIV+1 and D·DIV edges after it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_reg | input | 32 | Current control word: enables at 14:12, threshold at 23:16, delay at 31:24 |
| pend_flags | input | 3 | Stored pending status flags (completion, delay, reserved) |
| frame_done | input | 1 | One-cycle pulse per completed frame |
| ctrl_wr | input | 1 | One-cycle pulse when the control word is written |
| cmpl_set | output | 1 | Pulse that sets the completion flag |
| dly_set | output | 1 | Pulse that sets the delay flag |
| live_cnt | output | 8 | Current completion countdown value |
| live_tmr | output | 8 | Current delay timer value |
| irq | output | 1 | Interrupt line |

## Verification
The bench checks the last-frame boundary, where a design that fired one frame early or late, or forgot the reload, would show the wrong pulse cycle or a stale count. A threshold of zero must cost 256 frames; a design that treated zero as "every frame" or as "never" would fail. Two timer cases are covered: a completion that arrives while the timer runs must restart it, and a completion with a zero delay must leave it running, so designs that always restart or never restart give the wrong `live_tmr` value. The last case lines up a final completion with an expiry in the same cycle, where a design could drop one pulse or restart the timer it should let expire. It also walks every pending/enable combination of the interrupt and measures the tick spacing with a divided prescaler.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
    localparam int CTRL_W  = 32;
    localparam int FLD_W   = 8;
    localparam int THR_LSB = 16;
    localparam int DLY_LSB = 24;
    localparam int EN_LSB  = 12;
    localparam int EN_N    = 3;

    typedef logic [FLD_W-1:0] fld_t;

    typedef struct packed {
        fld_t            delay;
        fld_t            thresh;
        logic [EN_N-1:0] en;
    } coal_ctrl_t;

    typedef struct packed {
        logic cmpl;
        logic dly;
    } coal_evt_t;

    function automatic coal_ctrl_t split_ctrl(input logic [CTRL_W-1:0] w);
        coal_ctrl_t c;
        c.delay  = w[DLY_LSB +: FLD_W];
        c.thresh = w[THR_LSB +: FLD_W];
        c.en     = w[EN_LSB +: EN_N];
        return c;
    endfunction

    function automatic int tick_div(input longint ref_hz, input longint tmr_hz);
        if (tmr_hz <= 0 || ref_hz <= tmr_hz) return 1;
        return int'(ref_hz / tmr_hz);
    endfunction
endpackage

// File: rtl/coal_tick_gen.sv
module coal_tick_gen #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase;
            always_ff @(posedge clk) begin
                if (rst || phase == LAST) phase <= '0;
                else                      phase <= phase + 1'b1;
            end
            assign tick = (phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/coal_delay_tmr.sv
module coal_delay_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         frame_done,
    input  logic [W-1:0] delay,
    output logic         expire,
    output logic [W-1:0] tmr
);
    logic restart;

    assign restart = frame_done && (delay != '0);
    assign expire  = tick && (tmr == W'(1)) && !restart;

    always_ff @(posedge clk) begin
        if (rst)                      tmr <= '0;
        else if (restart)             tmr <= delay;
        else if (tick && tmr != '0)   tmr <= tmr - 1'b1;
    end
endmodule

// File: rtl/coal_thresh_ctr.sv
module coal_thresh_ctr #(
    parameter int W       = 8,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_done,
    input  logic         ctrl_wr,
    input  logic         expire,
    input  logic [W-1:0] thresh,
    output logic         hit,
    output logic [W-1:0] cnt
);
    logic reload;

    assign hit    = frame_done && (cnt == W'(1));
    assign reload = ctrl_wr || hit || expire;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= W'(RST_VAL);
        else if (reload)     cnt <= thresh;
        else if (frame_done) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
    import irq_coal_pkg::*;
#(
    parameter longint REF_HZ     = 50_000_000,
    parameter longint TIMER_HZ   = 50_000_000,
    parameter int     RST_THRESH = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_reg,
    input  logic [EN_N-1:0]   pend_flags,
    input  logic              frame_done,
    input  logic              ctrl_wr,
    output logic              cmpl_set,
    output logic              dly_set,
    output logic [FLD_W-1:0]  live_cnt,
    output logic [FLD_W-1:0]  live_tmr,
    output logic              irq
);
    localparam int DIV = tick_div(REF_HZ, TIMER_HZ);

    coal_ctrl_t ctl;
    coal_evt_t  evt;
    logic       tick;
    logic       unused_ctrl;

    assign ctl         = split_ctrl(ctrl_reg);
    assign unused_ctrl = ^{ctrl_reg[15], ctrl_reg[11:0]};

    coal_tick_gen #(.DIV(DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    coal_delay_tmr #(.W(FLD_W)) u_tmr (
        .clk(clk), .rst(rst), .tick(tick), .frame_done(frame_done),
        .delay(ctl.delay), .expire(evt.dly), .tmr(live_tmr)
    );

    coal_thresh_ctr #(.W(FLD_W), .RST_VAL(RST_THRESH)) u_ctr (
        .clk(clk), .rst(rst), .frame_done(frame_done), .ctrl_wr(ctrl_wr),
        .expire(evt.dly), .thresh(ctl.thresh), .hit(evt.cmpl), .cnt(live_cnt)
    );

    assign cmpl_set = evt.cmpl;
    assign dly_set  = evt.dly;
    assign irq      = |(pend_flags & ctl.en);
endmodule

// File: rtl/irq_coalescer_chk.sv
module irq_coalescer_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] ctrl_reg,
    input logic        frame_done,
    input logic        ctrl_wr,
    input logic        cmpl_set,
    input logic        dly_set,
    input logic [7:0]  live_cnt,
    input logic [7:0]  live_tmr
);
    AST_CMPL_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        cmpl_set |-> frame_done); // R2
    AST_CMPL_RELOADS: assert property (@(posedge clk) disable iff (rst)
        cmpl_set |=> live_cnt == $past(ctrl_reg[23:16])); // R2
    AST_FRAME_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !ctrl_wr && !cmpl_set && !dly_set) |=> live_cnt == $past(live_cnt) - 8'd1); // R3
    AST_DELAY_RESTART: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ctrl_reg[31:24] != 8'd0) |=> live_tmr == $past(ctrl_reg[31:24])); // R4
    AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (rst)
        dly_set |=> live_tmr == 8'd0); // R5
    AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (rst)
        dly_set |=> live_cnt == $past(ctrl_reg[23:16])); // R5
    AST_EXPIRE_FROM_ONE: assert property (@(posedge clk) disable iff (rst)
        dly_set |-> live_tmr == 8'd1); // R5
    AST_WRITE_RELOADS: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> live_cnt == $past(ctrl_reg[23:16])); // R6
endmodule

bind irq_coalescer irq_coalescer_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_reg(ctrl_reg), .frame_done(frame_done),
    .ctrl_wr(ctrl_wr), .cmpl_set(cmpl_set), .dly_set(dly_set),
    .live_cnt(live_cnt), .live_tmr(live_tmr)
);

// File: tb/irq_coalescer_test.sv
module irq_coalescer_test;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctrl_reg = 32'h0001_0000;
    logic [2:0]  pend_flags = 3'b000;
    logic        frame_done = 1'b0, ctrl_wr = 1'b0;
    logic        cmpl_set, dly_set, irq;
    logic [7:0]  live_cnt, live_tmr;

    logic [31:0] ctrl4 = 32'h0;
    logic        frame4 = 1'b0;
    logic        cmpl4, dly4, irq4;
    logic [7:0]  cnt4, tmr4;

    int total = 0, bad = 0;
    bit done = 0;

    always #(PER/2) clk = ~clk;

    irq_coalescer uut (
        .clk(clk), .rst(rst), .ctrl_reg(ctrl_reg), .pend_flags(pend_flags),
        .frame_done(frame_done), .ctrl_wr(ctrl_wr), .cmpl_set(cmpl_set),
        .dly_set(dly_set), .live_cnt(live_cnt), .live_tmr(live_tmr), .irq(irq)
    );

    irq_coalescer #(.TIMER_HZ(12_500_000)) uut_div4 (
        .clk(clk), .rst(rst), .ctrl_reg(ctrl4), .pend_flags(3'b000),
        .frame_done(frame4), .ctrl_wr(1'b0), .cmpl_set(cmpl4),
        .dly_set(dly4), .live_cnt(cnt4), .live_tmr(tmr4), .irq(irq4)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int dly, input int thr, input int en);
        return {8'(dly), 8'(thr), 1'b0, 3'(en), 12'h0};
    endfunction

    // one clock edge with the given strobes; c/d hold the pulses seen before it
    task automatic edge_with(input logic fd, input logic wr, output logic c, output logic d);
        frame_done = fd;
        ctrl_wr    = wr;
        #1;
        c = cmpl_set;
        d = dly_set;
        @(negedge clk);
        frame_done = 1'b0;
        ctrl_wr    = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cnt in reset", live_cnt, 1);
        chk("R1 tmr in reset", live_tmr, 0);
        chk("R1 pulses in reset", {cmpl_set, dly_set}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cnt after reset", live_cnt, 1);
        chk("R1 pulses after reset", {cmpl_set, dly_set}, 0);
    endtask

    task automatic t_count();
        logic c, d;
        ctrl_reg = mk(0, 3, 0);
        edge_with(0, 1, c, d);
        chk("R6 write reload", live_cnt, 3);
        edge_with(1, 0, c, d);
        chk("R2 frame1 pulse", c, 0);
        chk("R2 frame1 cnt", live_cnt, 2);
        edge_with(1, 0, c, d);
        chk("R2 frame2 pulse", c, 0);
        chk("R2 frame2 cnt", live_cnt, 1);
        edge_with(1, 0, c, d);
        chk("R2 frame3 pulse", c, 1);
        chk("R2 reload after hit", live_cnt, 3);
        edge_with(1, 0, c, d);
        ctrl_reg = mk(0, 5, 0);
        edge_with(1, 1, c, d);
        chk("R6 write beats decrement", live_cnt, 5);
    endtask

    task automatic t_wrap();
        logic c, d;
        int first = -1;
        ctrl_reg = mk(0, 0, 0);
        edge_with(0, 1, c, d);
        for (int i = 1; i <= 256; i++) begin
            edge_with(1, 0, c, d);
            if (c && first < 0) first = i;
        end
        chk("R3 zero threshold hit frame", first, 256);
        chk("R3 cnt after wrap", live_cnt, 0);
    endtask

    task automatic t_delay();
        logic c, d;
        ctrl_reg = mk(4, 200, 0);
        edge_with(0, 1, c, d);
        edge_with(1, 0, c, d);
        chk("R4 load on frame", live_tmr, 4);
        chk("R2 cnt", live_cnt, 199);
        edge_with(0, 0, c, d);
        edge_with(0, 0, c, d);
        chk("R5 ticks down", live_tmr, 2);
        edge_with(1, 0, c, d);
        chk("R4 restart while running", live_tmr, 4);
        ctrl_reg = mk(0, 200, 0);
        edge_with(0, 1, c, d);
        chk("R5 tick", live_tmr, 3);
        edge_with(1, 0, c, d);
        chk("R4 zero delay no restart", live_tmr, 2);
        chk("R2 cnt before expiry", live_cnt, 199);
        edge_with(0, 0, c, d);
        chk("R5 no early expiry", d, 0);
        edge_with(0, 0, c, d);
        chk("R5 expiry pulse", d, 1);
        chk("R5 tmr after expiry", live_tmr, 0);
        chk("R5 cnt reload on expiry", live_cnt, 200);
        edge_with(0, 0, c, d);
        chk("R5 idle timer quiet", {d, live_tmr}, 0);
    endtask

    task automatic t_same();
        logic c, d;
        ctrl_reg = mk(3, 50, 0);
        edge_with(1, 0, c, d);
        ctrl_reg = mk(0, 1, 0);
        edge_with(0, 1, c, d);
        chk("R7 setup cnt", live_cnt, 1);
        ctrl_reg = mk(0, 6, 0);
        edge_with(0, 0, c, d);
        chk("R7 setup tmr", live_tmr, 1);
        edge_with(1, 0, c, d);
        chk("R7 both pulses", {c, d}, 3);
        chk("R7 single reload", live_cnt, 6);
        chk("R7 timer not restarted", live_tmr, 0);
    endtask

    task automatic t_irq();
        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 8; e++) begin
                pend_flags = 3'(p);
                ctrl_reg   = mk(0, 6, e);
                #1;
                chk($sformatf("R8 irq p=%0d e=%0d", p, e), irq, int'((p & e) != 0));
            end
        end
        pend_flags = 3'b000;
        @(negedge clk);
    endtask

    task automatic t_prescale();
        int hit_at = -1;
        ctrl4  = mk(3, 9, 0);
        frame4 = 1'b1;
        @(negedge clk);
        frame4 = 1'b0;
        chk("R9 divided load", tmr4, 3);
        for (int k = 1; k <= 20; k++) begin
            #1;
            if (dly4 && hit_at < 0) hit_at = k;
            @(negedge clk);
        end
        chk("R9 expiry not before 9 edges", int'(hit_at >= 9), 1);
        chk("R9 expiry by 12 edges", int'(hit_at >= 1 && hit_at <= 12), 1);
        chk("R9 divided timer idle", tmr4, 0);
    endtask

    initial begin
        #(PER * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_count();
        t_wrap();
        t_delay();
        t_same();
        t_irq();
        t_prescale();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule